// File: doc/BRIEF.md
# Pipelined DDS Phase Accumulator

This block is the phase engine of a direct digital synthesizer. On every reference clock it adds a programmable increment to a 32-bit running phase. The phase wraps on overflow, and each wrap is one period of the synthesized tone. The output frequency is therefore fo = K·fc / 2^32, and K = 1 gives the finest step, fc / 2^32. The phase word goes to a downstream phase-to-amplitude stage, with a flag that marks when the word is meaningful.

The 32-bit add is not one adder. It is split into four 8-bit segments, one per pipeline stage. Each segment registers its carry for the next segment one cycle later, so the critical path is an 8-bit add. Skew registers delay each increment slice on the way in and each phase slice on the way out. Every output word is then the exact phase of one logical sample. A new increment takes effect on all segments at the same logical sample. This keeps the phase continuous when the frequency changes, with no reset and no jump.

Top module: `dds_phase_acc`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the increment register, the phase output and the valid flag to zero. After that edge, `phase` reads 0 and `phase_vld` reads 0.
- R2: `freq_word` is captured into the increment register only at an edge where `freq_load` is 1. At any other edge, a change on `freq_word` has no effect on the phase sequence.
- R3: While valid, each output phase minus the previous output phase, modulo 2^32, equals the increment in force for that logical sample.
- R4: The output after edge t equals a single-cycle reference accumulator's value after edge t-4. A load at edge L first changes the output step after edge L+5, and the phase does not jump.
- R5: `phase_vld` stays 0 for the first four edges after reset is released. It is 1 from the fourth edge onward until the next reset.
- R6: The phase wraps modulo 2^32. An increment of 0 holds the phase constant, and an increment of 0xFFFFFFFF steps it down by one.
- R7: An increment of 1 advances the output by exactly 1 per clock, which is the finest frequency step.
- R8: A carry out of any 8-bit segment reaches the next segment for the same logical sample, including a chain that ripples through all four segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Frequency increment K |
| freq_load | input | 1 | Captures `freq_word` at this edge |
| phase | output | 32 | Coherent phase word for the amplitude stage |
| phase_vld | output | 1 | High once the pipeline has filled |

## Verification
A fault in one segment or in its carry register shows up as a single byte of `phase` that drifts, or as steps off by a multiple of 256. The per-edge comparison against the reference catches it within five edges of the first sample it touches. A wrong skew depth on the increment or output path mixes two logical samples into one word. This shows at the first change of K, or at the first carry across a boundary. A wrong fill depth shows on the fourth edge after reset.

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int SEG_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic               freq_load,
  output logic [PHASE_W-1:0] phase,
  output logic               phase_vld
);
  localparam int NSEG = PHASE_W / SEG_W;

  logic [PHASE_W-1:0] k_reg;
  logic [PHASE_W-1:0] aligned;
  logic [NSEG-1:0]    fill;

  always_ff @(posedge clk)
    if (rst)            k_reg <= '0;
    else if (freq_load) k_reg <= freq_word;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [SEG_W-1:0] kpipe [i+1];
    logic [SEG_W-1:0] acc;
    logic [SEG_W-1:0] oskew [NSEG-i];
    logic             cin;
    logic             cout_q;

    assign kpipe[0] = k_reg[i*SEG_W +: SEG_W];
    for (genvar j = 1; j <= i; j++) begin : g_kd
      always_ff @(posedge clk)
        kpipe[j] <= rst ? '0 : kpipe[j-1];
    end

    if (i == 0) begin : g_c0
      assign cin = 1'b0;
    end else begin : g_cn
      assign cin = g_seg[i-1].cout_q;
    end

    if (i < NSEG-1) begin : g_mid
      logic [SEG_W:0] sum;
      assign sum = {1'b0, acc} + {1'b0, kpipe[i]} + {{SEG_W{1'b0}}, cin};
      always_ff @(posedge clk)
        if (rst) begin
          acc    <= '0;
          cout_q <= 1'b0;
        end else begin
          acc    <= sum[SEG_W-1:0];
          cout_q <= sum[SEG_W];
        end
    end else begin : g_top
      assign cout_q = 1'b0;
      always_ff @(posedge clk)
        acc <= rst ? '0 : acc + kpipe[i] + {{(SEG_W-1){1'b0}}, cin};
    end

    assign oskew[0] = acc;
    for (genvar j = 1; j < NSEG-i; j++) begin : g_od
      always_ff @(posedge clk)
        oskew[j] <= rst ? '0 : oskew[j-1];
    end
    assign aligned[i*SEG_W +: SEG_W] = oskew[NSEG-1-i];
  end

  always_ff @(posedge clk)
    if (rst) begin
      phase <= '0;
      fill  <= '0;
    end else begin
      phase <= aligned;
      fill  <= {fill[NSEG-2:0], 1'b1};
    end

  assign phase_vld = fill[NSEG-1];
endmodule

// File: rtl/dds_phase_acc_chk.sv
module dds_phase_acc_chk #(
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] freq_word,
  input logic               freq_load,
  input logic [PHASE_W-1:0] k_reg,
  input logic [PHASE_W-1:0] phase,
  input logic               phase_vld
);
  logic [2:0] since;
  always_ff @(posedge clk)
    if (rst) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (phase == '0 && !phase_vld && k_reg == '0));

  a_r5_fill_low: assert property (@(posedge clk) disable iff (rst)
    (since < 3'd4) |-> !phase_vld);

  a_r5_fill_high: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd4) |-> phase_vld);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    freq_load |=> (k_reg == $past(freq_word)));

  a_r2_no_load_hold: assert property (@(posedge clk) disable iff (rst)
    !freq_load |=> $stable(k_reg));

  a_r3_step_is_k: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd6) |-> (phase - $past(phase) == $past(k_reg, 5)));
endmodule

bind dds_phase_acc dds_phase_acc_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .freq_word(freq_word), .freq_load(freq_load),
  .k_reg(k_reg), .phase(phase), .phase_vld(phase_vld)
);

// File: tb/sim_dds_phase_acc.sv
module sim_dds_phase_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] freq_word = '0;
  logic        freq_load = 1'b0;
  logic [31:0] phase;
  logic        phase_vld;

  dds_phase_acc u0 (.clk(clk), .rst(rst), .freq_word(freq_word),
                    .freq_load(freq_load), .phase(phase), .phase_vld(phase_vld));

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  int    cyc    = 0;
  string tag    = "R1";

  // independent single-cycle reference
  logic [31:0] rk;
  logic [31:0] racc;
  logic [31:0] hist [0:4];
  logic [31:0] kh   [0:4];
  int          since;
  logic [31:0] prev_phase;
  bit          prev_vld;

  always @(posedge clk) begin
    if (rst) begin
      rk <= '0; racc <= '0; since <= 0;
      for (int i = 0; i < 5; i++) begin hist[i] <= '0; kh[i] <= '0; end
    end else begin
      racc    <= racc + rk;
      hist[0] <= racc + rk;
      kh[0]   <= rk;
      for (int i = 1; i < 5; i++) begin hist[i] <= hist[i-1]; kh[i] <= kh[i-1]; end
      if (freq_load) rk <= freq_word;
      if (since < 10) since <= since + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(phase === hist[4], tag, phase, hist[4]);
      chk(phase_vld === (since >= 4), "R5", {31'd0, phase_vld}, {31'd0, since >= 4});
      if (phase_vld && prev_vld && !rst)
        chk(phase - prev_phase === kh[4], "R3", phase - prev_phase, kh[4]);
      prev_phase = phase;
      prev_vld   = phase_vld && !rst;
    end
  end

  function automatic logic [31:0] pick(input int unsigned r);
    case (r % 6)
      0: return 32'd1;
      1: return 32'hFFFF_FFFF;
      2: return 32'h00FF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  task automatic load(input logic [31:0] k);
    @(negedge clk); freq_word = k; freq_load = 1'b1;
    @(negedge clk); freq_load = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4321));
    tag = "R1"; run(3);
    @(negedge clk); rst = 1'b0;
    tag = "R5"; run(6);
    tag = "R7"; load(32'd1); run(20);
    tag = "R6"; load(32'd0); run(10);
    tag = "R8"; load(32'h00FF_FFFF); run(40);
    tag = "R8"; load(32'h0000_0100); run(20);
    tag = "R6"; load(32'hFFFF_FFFF); run(20);
    tag = "R6"; load(32'h9000_0001); run(20);
    tag = "R2";
    repeat (30) begin @(negedge clk); freq_word = $urandom; end
    run(5);
    tag = "R4";
    repeat (3000) begin
      @(negedge clk);
      freq_word = pick($urandom);
      freq_load = ($urandom % 4) == 0;
    end
    @(negedge clk); freq_load = 1'b0; run(8);
    tag = "R1"; @(negedge clk); rst = 1'b1; run(2);
    @(negedge clk); rst = 1'b0;
    tag = "R5"; run(6);
    tag = "R4"; load(32'h1234_5678); run(12);
    load(32'h0000_0010); run(12);
    finish_run();
  end
endmodule